// File: doc/BRIEF.md
# Clock Divider Control Register Block

This block keeps the divider settings that a processor test chip's clock generator consumes. It holds the core, internal-bus and external-bus divider fields, which act as soon as they are written. It also holds the PLL reference, feedback and output divider fields. A write to a PLL field only stages the value in a pending copy. The pending copy moves to the outputs when a soft reset pulse arrives. Each divider output carries a field value N and means a divide ratio of N+1.

Three configuration registers sit behind a key lock, so software has to unlock them before any change. The usual sequence is: write the key to the lock register, read-modify-write the wanted fields with byte enables, then write any other value to the lock register. A sticky status flag rises when the core and internal-bus divider values stop forming a valid synchronous ratio. Software clears that flag.

Register offsets: 0x08 holds the immediate dividers (core in byte lane 0, internal bus in lane 1, external bus in lane 2). 0x14 is the lock. 0x1C holds the PLL output divider (lane 0) and the PLL reference divider (lane 1). 0x24 holds the PLL feedback divider (lane 0). 0x30 is the status register.

Top module: `clk_ctrl_regs`

## Requirements
- R1: A write of exactly 0x0000A05F to offset 0x14 (all 32 bits compared, byte enables ignored) unlocks the block, and a write of any other value there locks it. Bit 0 of a read from 0x14 is 1 while the block is locked.
- R2: While the block is locked, writes to 0x08, 0x1C and 0x24 change no register and no output.
- R3: An unlocked write to 0x08 updates core_div_o, ibus_div_o and ebus_div_o at the clock edge that accepts the write. Each output value N means a divide ratio of N+1.
- R4: A write updates only the byte lanes whose be_i bit is set. Every divider field occupies the low DIV_W bits of its own lane.
- R5: A write to a PLL field only changes its pending copy, and the PLL outputs stay as they are. A soft_rst_i pulse copies all three pending fields to the PLL outputs at the next edge.
- R6: A read of 0x1C returns the active PLL output and reference values, so a staged value only appears after a soft reset. A read of 0x24 returns the pending feedback value.
- R7: A soft reset leaves the lock state and the immediate divider fields unchanged.
- R8: ratio_err_o (also bit 0 of 0x30) is set one cycle after (ibus+1) stops being an integer multiple of (core+1) greater than 1. It stays set until software writes 1 to bit 0 of 0x30 with be_i[0] set, and it is only cleared while the ratio is valid.
- R9: After power-on reset the block is locked and has core=0, ibus=1, ebus=3, PLL out=1, ref=0, fb=9, with ratio_err_o low.
- R10: rdata_o shows the addressed register one cycle after a read strobe and holds otherwise. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| soft_rst_i | input | 1 | One-cycle soft reset pulse; applies pending PLL fields |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| rdata_o | output | 32 | Read data, valid one cycle after re_i |
| core_div_o | output | DIV_W | Core clock divider value |
| ibus_div_o | output | DIV_W | Internal bus clock divider value |
| ebus_div_o | output | DIV_W | External bus clock divider value |
| pll_ref_div_o | output | DIV_W | Active PLL reference divider |
| pll_fb_div_o | output | DIV_W | Active PLL feedback divider |
| pll_out_div_o | output | DIV_W | Active PLL output divider |
| ratio_err_o | output | 1 | Sticky ratio error flag |

## Verification
The assertions assume that soft_rst_i is a synchronous pulse. They also assume that only the accepted writes, gated by the lock, move the divider registers. The stimulus therefore pulses soft reset for a single cycle away from write strobes. It never asserts read and write in the same cycle. It clears the error flag only after the divider ratio has been made valid again, so the sticky property and the clear path are both exercised without overlap.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam logic [7:0] OFF_OSC  = 8'h08;
  localparam logic [7:0] OFF_LOCK = 8'h14;
  localparam logic [7:0] OFF_AUX  = 8'h1C;
  localparam logic [7:0] OFF_INIT = 8'h24;
  localparam logic [7:0] OFF_STAT = 8'h30;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;
  // PLL shadow field order
  localparam int PLL_OUT = 0;
  localparam int PLL_REF = 1;
  localparam int PLL_FB  = 2;
  localparam int PLL_N   = 3;
endpackage

// File: rtl/ccr_lock.sv
module ccr_lock import ccr_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_o <= 1'b1;
    else if (wr_i) locked_o <= (wdata_i != UNLOCK_KEY);
  end

  a_r1_key_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i == UNLOCK_KEY |=> !locked_o);
  a_r1_other_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i != UNLOCK_KEY |=> locked_o);
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(locked_o));
endmodule

// File: rtl/ccr_ratio_chk.sv
module ccr_ratio_chk #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] core_div_i,
  input  logic [DIV_W-1:0] ibus_div_i,
  output logic             bad_o
);
  logic [DIV_W:0] core_r, ibus_r;
  always_comb begin
    core_r = {1'b0, core_div_i} + 1'b1;
    ibus_r = {1'b0, ibus_div_i} + 1'b1;
    bad_o  = (ibus_r <= core_r) || ((ibus_r % core_r) != '0);
  end
endmodule

// File: rtl/ccr_pll_shadow.sv
module ccr_pll_shadow #(
  parameter int                    N     = 3,
  parameter int                    DIV_W = 8,
  parameter logic [N*DIV_W-1:0]    DEF   = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic [N-1:0]       wr_i,
  input  logic [N*DIV_W-1:0] wdata_i,
  output logic [N*DIV_W-1:0] pend_o,
  output logic [N*DIV_W-1:0] act_o
);
  for (genvar g = 0; g < N; g++) begin : g_fld
    logic [DIV_W-1:0] pend_q, act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= DEF[g*DIV_W +: DIV_W];
        act_q  <= DEF[g*DIV_W +: DIV_W];
      end else begin
        if (wr_i[g])    pend_q <= wdata_i[g*DIV_W +: DIV_W];
        if (soft_rst_i) act_q  <= pend_q;
      end
    end
    assign pend_o[g*DIV_W +: DIV_W] = pend_q;
    assign act_o[g*DIV_W +: DIV_W]  = act_q;

    a_r5_act_only_on_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !soft_rst_i |=> $stable(act_o[g*DIV_W +: DIV_W]));
    a_r5_soft_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_rst_i |=> act_o[g*DIV_W +: DIV_W] == $past(pend_o[g*DIV_W +: DIV_W]));
  end
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs import ccr_pkg::*; #(
  parameter int ADDR_W   = 8,
  parameter int DIV_W    = 8,   // must be <= 8: one field per byte lane
  parameter int CORE_DEF = 0,
  parameter int IBUS_DEF = 1,
  parameter int EBUS_DEF = 3,
  parameter int OUT_DEF  = 1,
  parameter int REF_DEF  = 0,
  parameter int FB_DEF   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        be_i,
  output logic [31:0]       rdata_o,
  output logic [DIV_W-1:0]  core_div_o,
  output logic [DIV_W-1:0]  ibus_div_o,
  output logic [DIV_W-1:0]  ebus_div_o,
  output logic [DIV_W-1:0]  pll_ref_div_o,
  output logic [DIV_W-1:0]  pll_fb_div_o,
  output logic [DIV_W-1:0]  pll_out_div_o,
  output logic              ratio_err_o
);
  localparam int PW = PLL_N * DIV_W;
  localparam logic [PW-1:0] PLL_DEF = {DIV_W'(FB_DEF), DIV_W'(REF_DEF), DIV_W'(OUT_DEF)};

  logic hit_osc, hit_lock, hit_aux, hit_init, hit_stat;
  assign hit_osc  = addr_i == ADDR_W'(OFF_OSC);
  assign hit_lock = addr_i == ADDR_W'(OFF_LOCK);
  assign hit_aux  = addr_i == ADDR_W'(OFF_AUX);
  assign hit_init = addr_i == ADDR_W'(OFF_INIT);
  assign hit_stat = addr_i == ADDR_W'(OFF_STAT);

  logic locked;
  ccr_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (we_i && hit_lock),
    .wdata_i  (wdata_i),
    .locked_o (locked)
  );

  logic osc_we;
  assign osc_we = we_i && hit_osc && !locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_div_o <= DIV_W'(CORE_DEF);
      ibus_div_o <= DIV_W'(IBUS_DEF);
      ebus_div_o <= DIV_W'(EBUS_DEF);
    end else if (osc_we) begin
      if (be_i[0]) core_div_o <= wdata_i[0  +: DIV_W];
      if (be_i[1]) ibus_div_o <= wdata_i[8  +: DIV_W];
      if (be_i[2]) ebus_div_o <= wdata_i[16 +: DIV_W];
    end
  end

  // PLL staging: aux lanes 0/1 -> out/ref, init lane 0 -> fb
  logic [PLL_N-1:0] pll_wr;
  logic [PW-1:0]    pll_wd, pll_pend, pll_act;
  assign pll_wr[PLL_OUT] = we_i && hit_aux  && !locked && be_i[0];
  assign pll_wr[PLL_REF] = we_i && hit_aux  && !locked && be_i[1];
  assign pll_wr[PLL_FB]  = we_i && hit_init && !locked && be_i[0];
  assign pll_wd[PLL_OUT*DIV_W +: DIV_W] = wdata_i[0 +: DIV_W];
  assign pll_wd[PLL_REF*DIV_W +: DIV_W] = wdata_i[8 +: DIV_W];
  assign pll_wd[PLL_FB*DIV_W  +: DIV_W] = wdata_i[0 +: DIV_W];

  ccr_pll_shadow #(.N(PLL_N), .DIV_W(DIV_W), .DEF(PLL_DEF)) u_pll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .wr_i       (pll_wr),
    .wdata_i    (pll_wd),
    .pend_o     (pll_pend),
    .act_o      (pll_act)
  );
  assign pll_out_div_o = pll_act[PLL_OUT*DIV_W +: DIV_W];
  assign pll_ref_div_o = pll_act[PLL_REF*DIV_W +: DIV_W];
  assign pll_fb_div_o  = pll_act[PLL_FB*DIV_W  +: DIV_W];

  logic ratio_bad, err_clr;
  ccr_ratio_chk #(.DIV_W(DIV_W)) u_ratio (
    .core_div_i (core_div_o),
    .ibus_div_i (ibus_div_o),
    .bad_o      (ratio_bad)
  );
  assign err_clr = we_i && hit_stat && be_i[0] && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ratio_err_o <= 1'b0;
    else if (ratio_bad) ratio_err_o <= 1'b1;
    else if (err_clr)   ratio_err_o <= 1'b0;
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_osc) begin
      rd_mux[0  +: DIV_W] = core_div_o;
      rd_mux[8  +: DIV_W] = ibus_div_o;
      rd_mux[16 +: DIV_W] = ebus_div_o;
    end else if (hit_lock) begin
      rd_mux[0] = locked;
    end else if (hit_aux) begin
      rd_mux[0 +: DIV_W] = pll_out_div_o;
      rd_mux[8 +: DIV_W] = pll_ref_div_o;
    end else if (hit_init) begin
      rd_mux[0 +: DIV_W] = pll_pend[PLL_FB*DIV_W +: DIV_W];
    end else if (hit_stat) begin
      rd_mux[0] = ratio_err_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  a_r2_locked_osc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && we_i && hit_osc |=> $stable(core_div_o) && $stable(ibus_div_o) && $stable(ebus_div_o));
  a_r7_soft_keeps_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i && !we_i |=> $stable(core_div_o) && $stable(ibus_div_o) && $stable(locked));
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_err_o && !err_clr |=> ratio_err_o);
  a_r8_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_bad |=> ratio_err_o);
  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_clk_ctrl_regs.sv
module tb_clk_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] be = '0;
  logic [31:0] rdata;
  logic [7:0] core_div, ibus_div, ebus_div, pref, pfb, pout;
  logic err;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 1'b0;

  always #2 clk = ~clk;

  clk_ctrl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .rdata_o(rdata),
    .core_div_o(core_div), .ibus_div_o(ibus_div), .ebus_div_o(ebus_div),
    .pll_ref_div_o(pref), .pll_fb_div_o(pfb), .pll_out_div_o(pout),
    .ratio_err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: read data valid one cycle after the strobe
  always @(posedge clk) rd_pend <= re;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R10 unexpected read actual=%h expected=none", rdata);
      end else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk); we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic soft_pulse();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 core", core_div, 0);  chk("R9 ibus", ibus_div, 1);
    chk("R9 ebus", ebus_div, 3);  chk("R9 pll out", pout, 1);
    chk("R9 pll ref", pref, 0);   chk("R9 pll fb", pfb, 9);
    chk("R9 err", err, 0);
    rd(8'h14, 32'h1, "R9 locked after reset");
    rd(8'h08, 32'h0003_0100, "R9 osc read");
    rd(8'h00, 32'h0, "R10 unmapped read");

    // R2 locked writes ignored
    wr(8'h08, 32'h0005_0302, 4'hF);
    wr(8'h1C, 32'h0000_0707, 4'hF);
    chk("R2 core locked", core_div, 0);
    rd(8'h08, 32'h0003_0100, "R2 osc unchanged");
    rd(8'h24, 32'h9, "R2 init unchanged");
    wr(8'h14, 32'h0000_A05E, 4'hF);
    rd(8'h14, 32'h1, "R1 near-miss key stays locked");

    // R1 unlock
    wr(8'h14, 32'h0000_A05F, 4'h1);
    rd(8'h14, 32'h0, "R1 unlocked");

    // R3 immediate
    wr(8'h08, 32'h0007_0301, 4'h7);
    chk("R3 core", core_div, 1); chk("R3 ibus", ibus_div, 3); chk("R3 ebus", ebus_div, 7);
    rd(8'h08, 32'h0007_0301, "R3 osc read");

    // R4 byte enables
    wr(8'h08, 32'h00AA_FF55, 4'h2);
    chk("R4 ibus lane", ibus_div, 8'hFF);
    chk("R4 core untouched", core_div, 1);
    chk("R4 ebus untouched", ebus_div, 7);
    wr(8'h08, 32'h0000_0300, 4'h2);

    // R8 non-integer ratio 5/2
    @(negedge clk);
    chk("R8 no err valid", err, 0);
    wr(8'h08, 32'h0000_0400, 4'h2);
    @(negedge clk);
    chk("R8 err set non-integer", err, 1);
    wr(8'h08, 32'h0000_0300, 4'h2);
    @(negedge clk);
    chk("R8 err sticky", err, 1);
    rd(8'h30, 32'h1, "R8 status read");
    wr(8'h30, 32'h1, 4'h1);
    chk("R8 err cleared", err, 0);
    // ratio of 1 is invalid
    wr(8'h08, 32'h0000_0101, 4'h3);
    @(negedge clk);
    chk("R8 err ratio one", err, 1);
    wr(8'h08, 32'h0000_0301, 4'h3);
    wr(8'h30, 32'h1, 4'h1);
    chk("R8 err cleared again", err, 0);

    // R5/R6 staged PLL fields
    wr(8'h1C, 32'h0000_0503, 4'h3);
    wr(8'h24, 32'h0000_000C, 4'h1);
    chk("R5 out held", pout, 1); chk("R5 ref held", pref, 0); chk("R5 fb held", pfb, 9);
    rd(8'h1C, 32'h0000_0001, "R6 aux shows active");
    rd(8'h24, 32'h0000_000C, "R6 init shows pending");
    soft_pulse();
    chk("R5 out applied", pout, 3); chk("R5 ref applied", pref, 5); chk("R5 fb applied", pfb, 12);
    rd(8'h1C, 32'h0000_0503, "R6 aux after soft reset");
    // R7
    chk("R7 core kept", core_div, 1); chk("R7 ibus kept", ibus_div, 3);
    rd(8'h14, 32'h0, "R7 lock kept");

    // R1 relock with other value, R2 PLL write ignored
    wr(8'h14, 32'h0000_1234, 4'hF);
    rd(8'h14, 32'h1, "R1 relocked");
    wr(8'h1C, 32'h0000_0007, 4'h1);
    soft_pulse();
    chk("R2 pll out locked", pout, 3);
    rd(8'h14, 32'h1, "R7 locked kept");

    repeat (3) @(negedge clk);
    chk("R10 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule